// File: doc/BRIEF.md
# Power-State-Aware Reset Generator

This block turns two asynchronous pins of a network controller into its internal reset signals. The first pin is an active-low bus reset and the second is an active-low isolate pin. The block also takes the device's current power-management state and a wake-enable bit. It drives three outputs:

- The initialization reset, which clears the configuration space, the MAC settings and the memories.
- A separate reset for the wake-up domain.
- A one-cycle flag that marks the bus leaving its unpowered state.

In the active states D0, D1 and D2, the initialization reset follows the bus reset level. In D3 the bus reset level is ignored; only its release starts a fixed-length pulse. Releasing the isolate pin starts the same pulse in every state. While wake is enabled, the wake-up domain is kept out of all of these resets, so its registers and any stored wake-up frame survive. While wake is disabled, the wake-up domain simply takes the initialization reset.

Both pins pass through a synchronizer before the block looks at them. Edges are found by comparing each synchronized sample with the one before it. A new edge that arrives during a pulse restarts the pulse at its full length.

Top module: `pwr_rst_gen`

## Requirements
- R1: With the power state at 2'b00 (D0), 2'b01 (D1) or 2'b10 (D2), `init_rst_o` is high while `bus_rst_n_i` is low. It rises two clock edges after `bus_rst_n_i` falls and drops two edges after `bus_rst_n_i` rises.
- R2: With the power state at 2'b11 (D3), a low level on `bus_rst_n_i` does not raise `init_rst_o`.
- R3: In D3, a rising edge on `bus_rst_n_i` raises `init_rst_o` two clock edges later. It then stays high for exactly PULSE_CYCLES cycles (default 21, about 640 ns at 33 MHz).
- R4: A rising edge on `isolate_n_i`, in any power state, raises `init_rst_o` two clock edges later for exactly PULSE_CYCLES cycles.
- R5: A trigger edge that arrives while a pulse is running restarts the pulse. `init_rst_o` then stays high for PULSE_CYCLES cycles counted from the new edge.
- R6: While `pme_en_i` is high and the startup interval has ended, `pme_rst_o` stays low whatever the bus reset and isolate pins do.
- R7: While `pme_en_i` is low, `pme_rst_o` equals `init_rst_o` in every cycle.
- R8: `bus_b0_entry_o` is high for exactly one cycle, two clock edges after each rising edge of `bus_rst_n_i`, in any power state.
- R9: From power-up, `init_rst_o` and `pme_rst_o` are both high until the synchronizers have filled, which takes two clock edges. A pin that is already high at that point counts as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| bus_rst_n_i | input | 1 | Bus reset pin, active low, asynchronous |
| isolate_n_i | input | 1 | Isolate pin, active low, asynchronous |
| pwr_state_i | input | 2 | Power state: 00 = D0, 01 = D1, 10 = D2, 11 = D3 |
| pme_en_i | input | 1 | Wake enable; when high, shields the wake-up domain |
| init_rst_o | output | 1 | Initialization reset, active high |
| pme_rst_o | output | 1 | Wake-up domain reset, active high |
| bus_b0_entry_o | output | 1 | One-cycle flag on bus reset release |

## Verification
Every result follows a pin change by two clock edges, which is the synchronizer depth.

The level-following reset in D0 to D2, the start of each pulse and the bus-entry flag all appear after the second edge. The bench drives the pins on falling edges and samples on falling edges, so a change driven at one falling edge shows up at the second falling edge after it. The bench also checks the value at the first falling edge, to confirm that nothing appears early.

Pulse lengths are counted one sample per cycle, starting at the first high sample. Each length is compared with PULSE_CYCLES, so a pulse that is one cycle short or one cycle long fails the check.

// File: rtl/prs_pkg.sv
`timescale 1ns/1ps
package prs_pkg;
    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pwr_state_e;
endpackage

// File: rtl/prs_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage synchronizer. Every stage powers up at zero, which
// for active-low pins reads as "asserted" until real samples arrive.
module prs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q = '0;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], din_i[b]};
            end

            always_ff @(posedge clk_i) begin
                chain_q <= chain_d;
            end

            assign dout_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/prs_pulse_timer.sv
`timescale 1ns/1ps
// Retriggerable pulse stretcher. The trigger cycle counts as the first
// cycle of the pulse, so the counter loads one less than the pulse length.
module prs_pulse_timer #(
    parameter int PULSE_CYCLES = 21
) (
    input  logic clk_i,
    input  logic en_i,
    input  logic trig_i,
    output logic active_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d;
    tmr_state_t st_q = '0;

    always_comb begin
        st_d = st_q;
        if (en_i && trig_i) begin
            st_d.cnt = RELOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign active_o = (en_i && trig_i) || (st_q.cnt != '0);

    assert_load_R3: assert property (@(posedge clk_i) disable iff (!en_i)
        trig_i |=> (st_q.cnt == RELOAD));

    assert_countdown_R3: assert property (@(posedge clk_i) disable iff (!en_i)
        (!trig_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_restart_R5: assert property (@(posedge clk_i) disable iff (!en_i)
        (trig_i && st_q.cnt != '0) |=> (st_q.cnt == RELOAD));
endmodule

// File: rtl/pwr_rst_gen.sv
`timescale 1ns/1ps
module pwr_rst_gen
    import prs_pkg::*;
#(
    parameter int PULSE_CYCLES = 21,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       bus_rst_n_i,
    input  logic       isolate_n_i,
    input  logic [1:0] pwr_state_i,
    input  logic       pme_en_i,
    output logic       init_rst_o,
    output logic       pme_rst_o,
    output logic       bus_b0_entry_o
);
    localparam int SW = $clog2(SYNC_STAGES + 1);
    localparam logic [SW-1:0] READY_AT = SW'(SYNC_STAGES);

    typedef struct packed {
        logic          bus_prev;
        logic          iso_prev;
        logic [SW-1:0] start_cnt;
    } gen_state_t;

    gen_state_t st_d;
    gen_state_t st_q = '0;

    logic [1:0] pins_sync;
    logic       bus_sync;
    logic       iso_sync;
    logic       ready;
    logic       in_d3;
    logic       bus_rise;
    logic       iso_rise;
    logic       trig;
    logic       level_rst;
    logic       pulse_active;

    prs_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk_i (clk_i),
        .din_i ({isolate_n_i, bus_rst_n_i}),
        .dout_o(pins_sync)
    );

    assign bus_sync = pins_sync[0];
    assign iso_sync = pins_sync[1];

    always_comb begin
        st_d          = st_q;
        st_d.bus_prev = bus_sync;
        st_d.iso_prev = iso_sync;
        if (st_q.start_cnt != READY_AT) begin
            st_d.start_cnt = st_q.start_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    always_comb begin
        ready     = (st_q.start_cnt == READY_AT);
        in_d3     = (pwr_rst_gen_state(pwr_state_i) == PS_D3);
        bus_rise  = ready && bus_sync && !st_q.bus_prev;
        iso_rise  = ready && iso_sync && !st_q.iso_prev;
        trig      = iso_rise || (bus_rise && in_d3);
        level_rst = ready && !bus_sync && !in_d3;
    end

    prs_pulse_timer #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) timer_i (
        .clk_i   (clk_i),
        .en_i    (ready),
        .trig_i  (trig),
        .active_o(pulse_active)
    );

    assign init_rst_o     = !ready || level_rst || pulse_active;
    assign pme_rst_o      = pme_en_i ? !ready : init_rst_o;
    assign bus_b0_entry_o = bus_rise;

    function automatic pwr_state_e pwr_rst_gen_state(input logic [1:0] raw);
        return pwr_state_e'(raw);
    endfunction

    assert_level_follow_R1: assert property (@(posedge clk_i) disable iff (!ready)
        (!in_d3 && !bus_sync) |-> init_rst_o);

    assert_d3_level_ignored_R2: assert property (@(posedge clk_i) disable iff (!ready)
        (in_d3 && !pulse_active && !iso_rise) |-> !init_rst_o);

    assert_pme_shield_R6: assert property (@(posedge clk_i) disable iff (!ready)
        pme_en_i |-> !pme_rst_o);

    assert_pme_follow_R7: assert property (@(posedge clk_i) disable iff (!ready)
        !pme_en_i |-> (pme_rst_o == init_rst_o));

    assert_b0_single_R8: assert property (@(posedge clk_i) disable iff (!ready)
        bus_b0_entry_o |=> !bus_b0_entry_o);

    assert_startup_hold_R9: assert property (@(posedge clk_i)
        !ready |-> (init_rst_o && pme_rst_o));
endmodule

// File: tb/pwr_rst_gen_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_gen_tb_top;
    localparam int TB_PULSE = 21;
    localparam time CLK_HALF = 4;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       bus_rst_n;
    logic       isolate_n;
    logic [1:0] pwr_state;
    logic       pme_en;
    logic       init_rst;
    logic       pme_rst;
    logic       b0_entry;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #CLK_HALF clk = ~clk;

    pwr_rst_gen #(
        .PULSE_CYCLES(TB_PULSE),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk_i         (clk),
        .bus_rst_n_i   (bus_rst_n),
        .isolate_n_i   (isolate_n),
        .pwr_state_i   (pwr_state),
        .pme_en_i      (pme_en),
        .init_rst_o    (init_rst),
        .pme_rst_o     (pme_rst),
        .bus_b0_entry_o(b0_entry)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called at the first sample where the pulse is visible; counts its length.
    task automatic measure_pulse(output int len);
        len = 0;
        while (init_rst && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_startup;
        // R9: before any clock edge both resets are held
        #1;
        check("R9 init at power-up", init_rst, 1);
        check("R9 pme at power-up", pme_rst, 1);
        step(TB_PULSE + 10);
        check("R9 init released after startup pulse", init_rst, 0);
    endtask

    task automatic t_level_follow;
        for (int s = 0; s < 3; s++) begin
            pwr_state = 2'(s);
            step(2);
            bus_rst_n = 1'b0;
            step(1);
            check("R1 no early assert", init_rst, 0);
            step(1);
            check("R1 asserted in active state", init_rst, 1);
            step(5);
            check("R1 held while low", init_rst, 1);
            bus_rst_n = 1'b1;
            step(1);
            check("R1 still held one edge after release", init_rst, 1);
            step(1);
            check("R1 released", init_rst, 0);
            check("R8 entry flag raised", b0_entry, 1);
            step(1);
            check("R8 entry flag one cycle", b0_entry, 0);
            check("R1 stays released", init_rst, 0);
        end
    endtask

    task automatic t_d3_bus;
        int len;
        pwr_state = 2'b11;
        step(2);
        bus_rst_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            check("R2 level ignored in D3", init_rst, 0);
        end
        bus_rst_n = 1'b1;
        step(1);
        check("R3 no pulse before sync", init_rst, 0);
        step(1);
        check("R8 entry flag in D3", b0_entry, 1);
        measure_pulse(len);
        check("R3 D3 pulse length", len, TB_PULSE);
        check("R3 released after pulse", init_rst, 0);
    endtask

    task automatic t_isolate;
        int len;
        pwr_state = 2'b01;
        step(2);
        isolate_n = 1'b0;
        step(4);
        isolate_n = 1'b1;
        step(2);
        measure_pulse(len);
        check("R4 isolate pulse length in D1", len, TB_PULSE);
        pwr_state = 2'b11;
        isolate_n = 1'b0;
        step(3);
        isolate_n = 1'b1;
        step(2);
        measure_pulse(len);
        check("R4 isolate pulse length in D3", len, TB_PULSE);
    endtask

    task automatic t_retrigger;
        int len;
        pwr_state = 2'b00;
        isolate_n = 1'b0;
        step(3);
        isolate_n = 1'b1;
        step(2);
        check("R5 first pulse started", init_rst, 1);
        step(8);
        isolate_n = 1'b0;
        step(1);
        isolate_n = 1'b1;
        step(2);
        measure_pulse(len);
        check("R5 pulse restarted at full length", len, TB_PULSE);
    endtask

    task automatic t_pme;
        int len;
        int mism;
        // R6: shielded domain
        pme_en = 1'b1;
        pwr_state = 2'b00;
        step(2);
        bus_rst_n = 1'b0;
        step(2);
        check("R6 init asserted", init_rst, 1);
        check("R6 pme shielded from bus reset", pme_rst, 0);
        bus_rst_n = 1'b1;
        isolate_n = 1'b0;
        step(3);
        isolate_n = 1'b1;
        step(2);
        check("R6 init pulse from isolate", init_rst, 1);
        check("R6 pme shielded from isolate", pme_rst, 0);
        step(TB_PULSE + 2);
        // R7: following domain across a D3 pulse
        pme_en = 1'b0;
        pwr_state = 2'b11;
        bus_rst_n = 1'b0;
        step(3);
        bus_rst_n = 1'b1;
        mism = 0;
        for (int i = 0; i < TB_PULSE + 6; i++) begin
            step(1);
            if (pme_rst != init_rst) mism++;
        end
        check("R7 pme follows init", mism, 0);
        pwr_state = 2'b10;
        bus_rst_n = 1'b0;
        step(2);
        check("R7 pme asserted with init", pme_rst, 1);
        bus_rst_n = 1'b1;
        step(2);
        check("R7 pme released with init", pme_rst, 0);
        len = 0;
    endtask

    initial begin
        bus_rst_n = 1'b1;
        isolate_n = 1'b1;
        pwr_state = 2'b00;
        pme_en    = 1'b0;
        t_startup();
        t_level_follow();
        t_d3_bus();
        t_isolate();
        t_retrigger();
        t_pme();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule